// File: doc/BRIEF.md
# Dual Event Counter Performance Monitor

This block counts hardware events on two independent 32-bit counters. Each counter advances by one for every clock cycle in which its event input is high, provided counting is globally enabled. Software reaches the block through a simple register port: a control/status word at address 0 and the two counters at addresses 1 and 2. Writing a counter presets it to any value. Writing a one to the clear bit in the control word zeroes both counters.

A counter that holds all ones wraps to zero on its next event. The wrap sets a sticky overflow flag in the control word, and that flag stays set until software writes a one to it. Each flag has its own interrupt enable. A single routing bit sends every enabled overflow to either the normal interrupt output or the fast interrupt output. Both outputs are levels that stay high while any enabled flag is set.

Software typically clears the counters, sets the interrupt enables and the routing bit, and then sets the global enable. It reads the counters at any time. On an interrupt it takes the overflow, counts it, and writes one to the flag to acknowledge it.

Top module: `evt_pmu_top`

## Requirements
- R1: After reset the control word reads 0 (counting disabled, no enables, no flags), and both interrupt outputs are low.
- R2: A write to address 1 or 2 loads counter 0 or counter 1 with the written value, and a read of that address then returns it.
- R3: Writing a control word with bit 1 set clears both counters to zero. Bit 1 always reads back as 0.
- R4: While control bit 0 is 1, a counter increases by exactly one for each cycle its event input is high. The other counter is not affected.
- R5: A counter at 0xFFFF_FFFF that receives an event becomes 0. Counter 0 wrapping sets control bit 8, and counter 1 wrapping sets control bit 9. These flags stay set afterwards.
- R6: While control bit 0 is 0, events leave both counters unchanged.
- R7: Writing 1 to control bit 8 or 9 clears that flag, and writing 0 leaves it as it is. If a wrap lands in the same cycle as the clearing write, the flag ends up set.
- R8: An interrupt is pending when flag 8 and enable bit 4 are both set, or when flag 9 and enable bit 5 are both set. With control bit 2 at 0 the pending state drives the normal output, and with bit 2 at 1 it drives the fast output. The two outputs are never high together.
- R9: A counter write in the same cycle as that counter's event loads the written value and drops the event. A clear in the same cycle as a wrap leaves the counter at 0 and does not set the flag.
- R10: Reads are combinational from the registered state: address 0 returns the control word, 1 returns counter 0, 2 returns counter 1, and 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 2 | Per-cycle event strobes, bit i for counter i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| int_norm_o | output | 1 | Normal-priority overflow interrupt (level) |
| int_fast_o | output | 1 | Fast overflow interrupt (level) |

## Verification
Two pairs of functions can act on the same cycle: a software write to a register and a counter event, and a clear or flag acknowledge and a counter wrap. The bench produces each collision by holding the event strobe high in the same clock cycle as the write strobe. The counter is first preset one step below the wrap, or to the wrap value, where the test needs it. The bench then judges the result against the priority rules. The written value or zero wins over the event. A wrap beats a flag acknowledge, but a clear suppresses the wrap. The bench reads back the counter, reads the flag bit, and checks the interrupt levels.

// File: rtl/pmu_pkg.sv
// Package: shared widths, register addresses and control-word bit positions
// for the dual event counter monitor.
package pmu_pkg;
    localparam int CNT_W   = 32;
    localparam int NUM_CNT = 2;
    localparam int ADDR_W  = 2;

    // Control-word bit positions (software visible)
    localparam int CB_EN     = 0;   // global count enable
    localparam int CB_CLR    = 1;   // write-1 pulse: clear both counters
    localparam int CB_SEL    = 2;   // 0: normal interrupt, 1: fast interrupt
    localparam int CB_IE_LSB = 4;   // per-counter interrupt enables
    localparam int CB_OV_LSB = 8;   // per-counter sticky overflow flags

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_CNT0 = 2'd1;
endpackage

// File: rtl/pmu_event_counter.sv
// Module: one event counter.
// Priority per cycle: clear, then software load, then a counted event.
// Assumes the counter needs no reset value (it is undefined until software
// clears or loads it). The wrap output pulses in the cycle in which an
// event moves the all-ones value to zero.
module pmu_event_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         count_en,
    input  logic         evt,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    logic bump;

    // Decide whether an event is counted this cycle.
    always_comb begin
        bump = count_en && evt && !clear && !load;
        wrap = bump && (&cnt);
    end

    // Update the counter value in priority order.
    always_ff @(posedge clk) begin
        if (clear)      cnt <= '0;
        else if (load)  cnt <= load_val;
        else if (bump)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pmu_ctrl_reg.sv
// Module: control/status register and interrupt routing.
// Holds the global enable, the routing select, the per-counter interrupt
// enables and the sticky overflow flags. Flags are cleared by writing 1.
// A wrap in the same cycle as a clearing write keeps the flag set.
// Assumes the write fields arrive already sliced out of the write data.
module pmu_ctrl_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         w_en,
    input  logic         w_sel,
    input  logic [N-1:0] w_ie,
    input  logic [N-1:0] w_ack,
    input  logic [N-1:0] wrap,
    output logic         en,
    output logic         sel,
    output logic [N-1:0] ie,
    output logic [N-1:0] flag,
    output logic         int_norm,
    output logic         int_fast
);
    logic [N-1:0] ack_mask;
    logic         pending;

    // Form the acknowledge mask and the routed interrupt levels.
    always_comb begin
        ack_mask = wr ? w_ack : '0;
        pending  = |(flag & ie);
        int_norm = pending && !sel;
        int_fast = pending && sel;
    end

    // Register the control fields and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            sel  <= 1'b0;
            ie   <= '0;
            flag <= '0;
        end else begin
            if (wr) begin
                en  <= w_en;
                sel <= w_sel;
                ie  <= w_ie;
            end
            flag <= (flag & ~ack_mask) | wrap;
        end
    end
endmodule

// File: rtl/evt_pmu_top.sv
// Module: top of the dual event counter monitor.
// Decodes the register port, instantiates one counter per event input and
// the control register, and returns read data combinationally.
// Assumes CNT_W is at least CB_OV_LSB + NUM_CNT bits so the control word fits.
module evt_pmu_top
    import pmu_pkg::*;
#(
    parameter int W = pmu_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CNT-1:0] evt_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              int_norm_o,
    output logic              int_fast_o
);
    localparam int N = NUM_CNT;

    logic              ctrl_wr;
    logic              clr_all;
    logic              en_q;
    logic              sel_q;
    logic [N-1:0]      ie_q;
    logic [N-1:0]      flag_q;
    logic [N-1:0]      wrap;
    logic [N-1:0][W-1:0] cnt_q;
    logic [W-1:0]      ctrl_word;

    // Decode a control write and the clear pulse it may carry.
    always_comb begin
        ctrl_wr = reg_we && (reg_addr == A_CTRL);
        clr_all = ctrl_wr && reg_wdata[CB_CLR];
    end

    // One counter per event input, mapped at consecutive addresses.
    for (genvar i = 0; i < N; i++) begin : g_cnt
        logic load_i;
        always_comb load_i = reg_we && (reg_addr == A_CNT0 + ADDR_W'(i));

        pmu_event_counter #(.W(W)) u_cnt (
            .clk      (clk),
            .count_en (en_q),
            .evt      (evt_in[i]),
            .clear    (clr_all),
            .load     (load_i),
            .load_val (reg_wdata),
            .cnt      (cnt_q[i]),
            .wrap     (wrap[i])
        );
    end

    pmu_ctrl_reg #(.N(N)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .w_en     (reg_wdata[CB_EN]),
        .w_sel    (reg_wdata[CB_SEL]),
        .w_ie     (reg_wdata[CB_IE_LSB +: N]),
        .w_ack    (reg_wdata[CB_OV_LSB +: N]),
        .wrap     (wrap),
        .en       (en_q),
        .sel      (sel_q),
        .ie       (ie_q),
        .flag     (flag_q),
        .int_norm (int_norm_o),
        .int_fast (int_fast_o)
    );

    // Assemble the control word as software sees it.
    always_comb begin
        ctrl_word                     = '0;
        ctrl_word[CB_EN]              = en_q;
        ctrl_word[CB_SEL]             = sel_q;
        ctrl_word[CB_IE_LSB +: N]     = ie_q;
        ctrl_word[CB_OV_LSB +: N]     = flag_q;
    end

    // Return read data for the addressed register.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata = ctrl_word;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (reg_addr == A_CNT0 + ADDR_W'(k)) reg_rdata = cnt_q[k];
            end
        end
    end
endmodule

// File: rtl/evt_pmu_chk.sv
// Module: assertion checker for evt_pmu_top, attached by bind.
// Observes the port activity and the counter and flag state across cycles.
module evt_pmu_chk
    import pmu_pkg::*;
#(
    parameter int W = pmu_pkg::CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        evt_in,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [W-1:0]      reg_wdata,
    input logic              int_norm_o,
    input logic              int_fast_o,
    input logic              en_q,
    input logic [1:0]        flag_q,
    input logic [W-1:0]      c0,
    input logic [W-1:0]      c1
);
    logic wr0, clr, idle0;
    always_comb begin
        wr0   = reg_we && reg_addr == A_CNT0;
        clr   = reg_we && reg_addr == A_CTRL && reg_wdata[CB_CLR];
        idle0 = !reg_we;
    end

    AST_LOAD_CNT0: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> c0 == $past(reg_wdata)); // R2
    AST_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (c0 == '0 && c1 == '0)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (idle0 && en_q && evt_in[0]) |=> c0 == $past(c0) + 1'b1); // R4
    AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (idle0 && en_q && evt_in[1] && (&c1)) |=> flag_q[1]); // R5
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle0 && !en_q) |=> ($stable(c0) && $stable(c1))); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && idle0) |=> flag_q[0]); // R7
    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_norm_o && int_fast_o)); // R8
endmodule

bind evt_pmu_top evt_pmu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_in     (evt_in),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .int_norm_o (int_norm_o),
    .int_fast_o (int_fast_o),
    .en_q       (en_q),
    .flag_q     (flag_q),
    .c0         (cnt_q[0]),
    .c1         (cnt_q[1])
);

// File: tb/evt_pmu_top_tb.sv
// Bench: near-exhaustive sweeps of presets and event counts around the wrap
// point, plus the collision cases, with arithmetic expected values.
module evt_pmu_top_tb;
    localparam int  W   = 32;
    localparam time TCK = 20ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   evt_in = '0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = '0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic         int_norm_o, int_fast_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(TCK/2) clk = ~clk;

    evt_pmu_top u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_norm_o(int_norm_o), .int_fast_o(int_fast_o)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [1:0] mask, input int n);
        if (n > 0) begin
            @(negedge clk);
            evt_in = mask;
            repeat (n) @(negedge clk);
            evt_in = '0;
        end
    endtask

    initial begin
        #(TCK * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v, other0, other1, pre;
        logic [W:0]   sum;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        rd(2'd0, v); chk("R1 ctrl", v, '0);
        chk("R1 irq", {30'd0, int_norm_o, int_fast_o}, '0);

        // R3: clear both, clear bit reads 0
        wr(2'd0, 32'h2);
        rd(2'd1, v); chk("R3 cnt0", v, '0);
        rd(2'd2, v); chk("R3 cnt1", v, '0);
        rd(2'd0, v); chk("R3 ctrl bit1", v, '0);

        // R2 / R10: loads and address map
        wr(2'd1, 32'hA5A5_1234);
        wr(2'd2, 32'h0F0F_9876);
        rd(2'd1, v); chk("R2 cnt0", v, 32'hA5A5_1234);
        rd(2'd2, v); chk("R2 cnt1", v, 32'h0F0F_9876);
        rd(2'd3, v); chk("R10 addr3", v, '0);

        // R6: disabled, events ignored
        pulse(2'b11, 5);
        rd(2'd1, v); chk("R6 cnt0", v, 32'hA5A5_1234);
        rd(2'd2, v); chk("R6 cnt1", v, 32'h0F0F_9876);

        // R4 / R5: sweep presets near wrap and event counts, per counter
        for (int c = 0; c < 2; c++) begin
            for (int off = 0; off < 6; off++) begin
                for (int n = 0; n < 8; n++) begin
                    wr(2'd0, 32'h300);
                    pre = 32'hFFFF_FFFF - off;
                    wr(2'(c + 1), pre);
                    rd(2'd1, other0); rd(2'd2, other1);
                    wr(2'd0, 32'h1);
                    pulse(2'(1 << c), n);
                    wr(2'd0, 32'h0);
                    sum = {1'b0, pre} + n;
                    rd(2'(c + 1), v); chk("R4 R5 count", v, sum[W-1:0]);
                    rd(2'(2 - c), v);
                    chk("R4 other", v, (c == 0) ? other1 : other0);
                    rd(2'd0, v);
                    chk("R5 flag", {31'd0, v[8 + c]}, {31'd0, sum[W]});
                end
            end
        end

        // R5 sticky: flag 0 set stays after more counting
        wr(2'd0, 32'h300);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h1);
        pulse(2'b01, 3);
        rd(2'd0, v); chk("R5 sticky", v, 32'h101);
        // R7: writing 0 keeps, writing 1 clears
        wr(2'd0, 32'h001);
        rd(2'd0, v); chk("R7 write0", v, 32'h101);
        // R8: enabled overflow on normal output
        wr(2'd0, 32'h011);
        chk("R8 norm", {30'd0, int_norm_o, int_fast_o}, 32'h2);
        wr(2'd0, 32'h015);
        chk("R8 fast", {30'd0, int_norm_o, int_fast_o}, 32'h1);
        wr(2'd0, 32'h025);
        chk("R8 ie mismatch", {30'd0, int_norm_o, int_fast_o}, 32'h0);
        wr(2'd0, 32'h111);
        rd(2'd0, v); chk("R7 w1c", v, 32'h011);
        chk("R8 cleared", {30'd0, int_norm_o, int_fast_o}, 32'h0);

        // R7: wrap in same cycle as acknowledge keeps flag
        wr(2'd1, 32'hFFFF_FFFF);
        pulse(2'b01, 1);
        wr(2'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h101; evt_in = 2'b01;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; evt_in = '0;
        rd(2'd0, v); chk("R7 wrap beats ack", v, 32'h101);
        rd(2'd1, v); chk("R7 wrap cnt", v, '0);

        // R9: load in same cycle as event
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_0040; evt_in = 2'b10;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; evt_in = '0;
        rd(2'd2, v); chk("R9 load wins", v, 32'h0000_0040);

        // R9: clear in same cycle as wrap
        wr(2'd0, 32'h301);
        wr(2'd2, 32'hFFFF_FFFF);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h003; evt_in = 2'b10;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0; evt_in = '0;
        rd(2'd2, v); chk("R9 clear cnt", v, '0);
        rd(2'd0, v); chk("R9 no flag", v, 32'h001);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule